// File: doc/BRIEF.md
# USB Host Schedule Walker

This block picks, one at a time, the transfer descriptor that a USB host controller executes next. It keeps a microframe counter and a frame index. The frame index advances once every eight microframes. On the first microframe of each frame it reads one entry of a periodic frame list held in an internal table. That table is organised as rows of priority slots. The row is chosen by the low bits of the frame index. Slot 0 is the most urgent, and each slot holds a valid flag, an interval exponent and a descriptor pointer.

When the periodic work of a microframe is finished, or when the microframe is not the first of its frame, the block serves a ring of asynchronous queue-head slots in round-robin order. The round-robin position is kept across microframes. Slots can be filled or emptied at any time. A budget counter is reloaded at every start-of-microframe pulse. An asynchronous dispatch starts only while that budget is at or above a software-chosen threshold.

Each chosen pointer is offered on an execution port with a valid/ready handshake. The block then waits for a done pulse before it chooses again, so at most one descriptor is ever in flight. A start-of-microframe pulse that arrives while a descriptor is in flight is held, and it takes effect as soon as that descriptor completes.

Top module: `usb_sched_walker`

## Requirements
- R1: After reset `ex_valid` is 0, `frame_idx` is all ones and `uframe` is 7, so the first `sof_i` pulse opens microframe 0 of frame 0. Nothing is dispatched before that first pulse.
- R2: Each `sof_i` pulse adds one to `uframe`, modulo 8. The pulse that takes `uframe` from 7 to 0 also adds one to `frame_idx`. Without a pulse, neither value changes.
- R3: In a microframe with `uframe` equal to 0, the periodic row numbered `frame_idx mod FL_ENTRIES` is walked from slot 0 upward. This walk completes before any asynchronous dispatch of that microframe. No periodic dispatch happens in any other microframe.
- R4: A periodic slot is dispatched only if its valid flag is 1 and `frame_idx mod 2^e` is 0, where e is the slot's interval exponent. All other slots are skipped.
- R5: Asynchronous service picks the first valid ring slot that follows the last slot served, wrapping at `NQH`. It starts from slot 0 after reset, and the position carries over from one microframe to the next.
- R6: A ring slot write (`aq_we` with `aq_valid` set or cleared) takes part in the very next asynchronous choice, even when it happens while a descriptor is in flight.
- R7: The budget is loaded with `UF_CYCLES` at each `sof_i` and drops by one per cycle, stopping at 0. An asynchronous dispatch is started only when the budget is at least `async_thr`. Once the budget is below the threshold, the block stays idle until the next `sof_i`. Periodic dispatch ignores the budget.
- R8: While `ex_valid` is 1 and `ex_ready` is 0, `ex_valid`, `ex_ptr` and `ex_async` hold their values. After the handshake, `ex_valid` stays 0 until `ex_done` has pulsed.
- R9: A `sof_i` pulse that arrives while a descriptor is offered or in flight is deferred. When `ex_done` arrives, the new microframe begins at once and the rest of the old periodic row is abandoned.
- R10: `ex_async` is 0 for a periodic dispatch and 1 for an asynchronous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | One-cycle start-of-microframe pulse |
| pl_we | input | 1 | Write strobe for the periodic table |
| pl_entry | input | FL_AW | Periodic row to write |
| pl_slot | input | EL_AW | Priority slot within the row (0 = highest) |
| pl_valid | input | 1 | Valid flag to store |
| pl_exp | input | EXP_W | Interval exponent (interval = 2^exp frames) |
| pl_ptr | input | PTR_W | Descriptor pointer to store |
| aq_we | input | 1 | Write strobe for the asynchronous ring |
| aq_slot | input | QH_AW | Ring slot to write |
| aq_valid | input | 1 | 1 inserts the slot into the ring, 0 removes it |
| aq_ptr | input | PTR_W | Queue-head pointer to store |
| async_thr | input | BUD_W | Minimum budget needed to start an asynchronous dispatch |
| ex_valid | output | 1 | A descriptor pointer is offered |
| ex_async | output | 1 | Kind of the offered descriptor (0 periodic, 1 asynchronous) |
| ex_ptr | output | PTR_W | Offered descriptor pointer |
| ex_ready | input | 1 | Executor accepts the offer |
| ex_done | input | 1 | One-cycle pulse: the accepted descriptor has finished |
| frame_idx | output | FIDX_W | Current frame index |
| uframe | output | 3 | Current microframe within the frame |

## Verification
The hardest situation to reach from the ports is a start-of-microframe pulse that lands while a periodic descriptor is in flight, with later slots of the same row still due. The bench first steps the frame index to a row whose first two slots are both due. It accepts the first one, then pulses `sof_i` and lowers the threshold before it returns the done pulse. This shows that the next offer comes from the asynchronous ring and not from the abandoned row. The round-robin carry-over is reached in a similar way. Pulses are injected only while a dispatch is outstanding, so the table can predict exactly which ring slot follows each microframe boundary.

// File: rtl/usb_sched_walker.sv
module usb_sched_walker #(
  parameter int FL_ENTRIES = 4,
  parameter int ELEMS      = 4,
  parameter int NQH        = 4,
  parameter int PTR_W      = 16,
  parameter int FIDX_W     = 11,
  parameter int EXP_W      = 3,
  parameter int UF_CYCLES  = 1000,
  localparam int FL_AW = $clog2(FL_ENTRIES),
  localparam int EL_AW = $clog2(ELEMS),
  localparam int QH_AW = $clog2(NQH),
  localparam int BUD_W = $clog2(UF_CYCLES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              pl_we,
  input  logic [FL_AW-1:0]  pl_entry,
  input  logic [EL_AW-1:0]  pl_slot,
  input  logic              pl_valid,
  input  logic [EXP_W-1:0]  pl_exp,
  input  logic [PTR_W-1:0]  pl_ptr,
  input  logic              aq_we,
  input  logic [QH_AW-1:0]  aq_slot,
  input  logic              aq_valid,
  input  logic [PTR_W-1:0]  aq_ptr,
  input  logic [BUD_W-1:0]  async_thr,
  output logic              ex_valid,
  output logic              ex_async,
  output logic [PTR_W-1:0]  ex_ptr,
  input  logic              ex_ready,
  input  logic              ex_done,
  output logic [FIDX_W-1:0] frame_idx,
  output logic [2:0]        uframe
);
  localparam int MA_W  = FL_AW + EL_AW;
  localparam int MEM_D = FL_ENTRIES * ELEMS;

  typedef enum logic [2:0] {S_IDLE, S_PER, S_ASY, S_OFFER, S_WAIT} st_t;

  st_t               state;
  logic              pend, ret_per;
  logic [2:0]        cur_uf;
  logic [FIDX_W-1:0] cur_f;
  logic [BUD_W-1:0]  budget;
  logic [EL_AW-1:0]  slot;
  logic [QH_AW-1:0]  rr;
  logic [PTR_W-1:0]  ptr_q;
  logic              async_q;

  logic              pt_v [MEM_D];
  logic [EXP_W-1:0]  pt_e [MEM_D];
  logic [PTR_W-1:0]  pt_p [MEM_D];
  logic              rg_v [NQH];
  logic [PTR_W-1:0]  rg_p [NQH];

  // periodic table and ring storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_D; i++) pt_v[i] <= 1'b0;
      for (int i = 0; i < NQH; i++) rg_v[i] <= 1'b0;
    end else begin
      if (pl_we) pt_v[{pl_entry, pl_slot}] <= pl_valid;
      if (aq_we) rg_v[aq_slot] <= aq_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (pl_we) begin
      pt_e[{pl_entry, pl_slot}] <= pl_exp;
      pt_p[{pl_entry, pl_slot}] <= pl_ptr;
    end
    if (aq_we) rg_p[aq_slot] <= aq_ptr;
  end

  // periodic slot evaluation
  logic [MA_W-1:0]   rd_a;
  logic [FIDX_W-1:0] fmask;
  logic              due;
  assign rd_a  = {cur_f[FL_AW-1:0], slot};
  assign fmask = (FIDX_W'(1) << pt_e[rd_a]) - FIDX_W'(1);
  assign due   = pt_v[rd_a] && ((cur_f & fmask) == '0);

  // round-robin search over the ring
  logic             found;
  logic [QH_AW-1:0] pick;
  always_comb begin
    logic [QH_AW-1:0] idx;
    found = 1'b0;
    pick  = '0;
    idx   = '0;
    for (int k = 1; k <= NQH; k++) begin
      idx = rr + QH_AW'(k);
      if (!found && rg_v[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  logic       start_now, slot_last, bud_ok;
  logic [2:0] nuf;
  st_t        st_new;
  assign start_now = sof_i | pend;
  assign nuf       = sof_i ? 3'(cur_uf + 3'd1) : cur_uf;
  assign st_new    = (nuf == 3'd0) ? S_PER : S_ASY;
  assign slot_last = (slot == EL_AW'(ELEMS - 1));
  assign bud_ok    = (budget >= async_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pend    <= 1'b0;
      ret_per <= 1'b0;
      cur_uf  <= 3'd7;
      cur_f   <= '1;
      budget  <= '0;
      slot    <= '0;
      rr      <= QH_AW'(NQH - 1);
      ptr_q   <= '0;
      async_q <= 1'b0;
    end else begin
      if (sof_i) begin
        cur_uf <= 3'(cur_uf + 3'd1);
        if (cur_uf == 3'd7) cur_f <= cur_f + FIDX_W'(1);
        budget <= BUD_W'(UF_CYCLES);
      end else if (budget != '0) begin
        budget <= budget - BUD_W'(1);
      end

      unique case (state)
        S_IDLE: if (start_now) begin
          pend <= 1'b0; slot <= '0; state <= st_new;
        end
        S_PER: begin
          if (start_now) begin
            pend <= 1'b0; slot <= '0; state <= st_new;
          end else if (due) begin
            ptr_q <= pt_p[rd_a]; async_q <= 1'b0; ret_per <= 1'b1;
            state <= S_OFFER;
          end else if (slot_last) begin
            state <= S_ASY;
          end else begin
            slot <= slot + EL_AW'(1);
          end
        end
        S_ASY: begin
          if (start_now) begin
            pend <= 1'b0; slot <= '0; state <= st_new;
          end else if (!bud_ok) begin
            state <= S_IDLE;
          end else if (found) begin
            ptr_q <= rg_p[pick]; async_q <= 1'b1; ret_per <= 1'b0;
            rr <= pick;
            state <= S_OFFER;
          end
        end
        S_OFFER: begin
          if (sof_i) pend <= 1'b1;
          if (ex_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (ex_done) begin
            if (start_now) begin
              pend <= 1'b0; slot <= '0; state <= st_new;
            end else if (ret_per && !slot_last) begin
              slot <= slot + EL_AW'(1); state <= S_PER;
            end else begin
              state <= S_ASY;
            end
          end else if (sof_i) begin
            pend <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ex_valid  = (state == S_OFFER);
  assign ex_ptr    = ptr_q;
  assign ex_async  = async_q;
  assign frame_idx = cur_f;
  assign uframe    = cur_uf;

  p_offer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_ready |=> ex_valid && $stable(ex_ptr) && $stable(ex_async));

  p_single_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && ex_ready |=> !ex_valid);

  p_frame_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i && uframe == 3'd7 |=> frame_idx == $past(frame_idx) + FIDX_W'(1) && uframe == 3'd0);

  p_counters_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_i |=> $stable(uframe) && $stable(frame_idx));

  p_periodic_uf0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ex_valid) && !ex_async |-> uframe == 3'd0);

  p_budget_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ex_valid) && ex_async |-> $past(budget) >= $past(async_thr));
endmodule

// File: tb/sim_usb_sched_walker.sv
module sim_usb_sched_walker;
  localparam int FL_ENTRIES = 4, ELEMS = 4, NQH = 4, PTR_W = 16, FIDX_W = 11, EXP_W = 3;
  localparam int UF_CYCLES = 1000;
  localparam int BUD_W = $clog2(UF_CYCLES + 2);

  logic clk = 1'b0, rst_n = 1'b0, sof_i = 1'b0;
  logic pl_we = 1'b0, pl_valid = 1'b0;
  logic [1:0] pl_entry = '0, pl_slot = '0;
  logic [EXP_W-1:0] pl_exp = '0;
  logic [PTR_W-1:0] pl_ptr = '0;
  logic aq_we = 1'b0, aq_valid = 1'b0;
  logic [1:0] aq_slot = '0;
  logic [PTR_W-1:0] aq_ptr = '0;
  logic [BUD_W-1:0] async_thr = '0;
  logic ex_valid, ex_async, ex_ready = 1'b0, ex_done = 1'b0;
  logic [PTR_W-1:0] ex_ptr;
  logic [FIDX_W-1:0] frame_idx;
  logic [2:0] uframe;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  usb_sched_walker #(.FL_ENTRIES(FL_ENTRIES), .ELEMS(ELEMS), .NQH(NQH), .PTR_W(PTR_W),
    .FIDX_W(FIDX_W), .EXP_W(EXP_W), .UF_CYCLES(UF_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i),
    .pl_we(pl_we), .pl_entry(pl_entry), .pl_slot(pl_slot), .pl_valid(pl_valid),
    .pl_exp(pl_exp), .pl_ptr(pl_ptr),
    .aq_we(aq_we), .aq_slot(aq_slot), .aq_valid(aq_valid), .aq_ptr(aq_ptr),
    .async_thr(async_thr), .ex_valid(ex_valid), .ex_async(ex_async), .ex_ptr(ex_ptr),
    .ex_ready(ex_ready), .ex_done(ex_done), .frame_idx(frame_idx), .uframe(uframe));

  // {sof before this dispatch, expected kind, expected pointer}
  localparam logic [17:0] VEC [16] = '{
    {1'b1, 1'b0, 16'h0A00}, {1'b0, 1'b0, 16'h0A02}, {1'b0, 1'b0, 16'h0A03},
    {1'b0, 1'b1, 16'hC000}, {1'b0, 1'b1, 16'hC002}, {1'b1, 1'b1, 16'hC003},
    {1'b0, 1'b1, 16'hC000}, {1'b1, 1'b1, 16'hC002}, {1'b1, 1'b1, 16'hC003},
    {1'b1, 1'b1, 16'hC000}, {1'b1, 1'b1, 16'hC002}, {1'b1, 1'b1, 16'hC003},
    {1'b1, 1'b1, 16'hC000}, {1'b1, 1'b0, 16'h0B00}, {1'b0, 1'b1, 16'hC002},
    {1'b0, 1'b1, 16'hC003}};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sof_pulse();
    sof_i = 1'b1; tick(1); sof_i = 1'b0;
  endtask

  task automatic wpl(input int e, input int s, input bit v, input int x, input logic [15:0] p);
    pl_we = 1'b1; pl_entry = 2'(e); pl_slot = 2'(s); pl_valid = v; pl_exp = EXP_W'(x); pl_ptr = p;
    tick(1); pl_we = 1'b0;
  endtask

  task automatic waq(input int s, input bit v, input logic [15:0] p);
    aq_we = 1'b1; aq_slot = 2'(s); aq_valid = v; aq_ptr = p;
    tick(1); aq_we = 1'b0;
  endtask

  task automatic take(input logic [15:0] eptr, input bit easync, input string req);
    int w = 0;
    while (!ex_valid && w < 300) begin tick(1); w++; end
    if (!ex_valid) begin
      chk(1'b0, req, "no offer seen", 32'(ex_valid), 32'h1);
      return;
    end
    chk(ex_ptr == eptr, req, "offered pointer", 32'(ex_ptr), 32'(eptr));
    chk(ex_async == easync, "R10", "descriptor kind", 32'(ex_async), 32'(easync));
    tick(2);
    chk(ex_valid && ex_ptr == eptr, "R8", "offer held without ready", 32'(ex_ptr), 32'(eptr));
    ex_ready = 1'b1; tick(1); ex_ready = 1'b0;
    tick(2);
    chk(!ex_valid, "R8", "no offer while in flight", 32'(ex_valid), 32'h0);
  endtask

  task automatic done_pulse();
    ex_done = 1'b1; tick(1); ex_done = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    repeat (n) begin tick(1); if (ex_valid) seen = 1'b1; end
    chk(!seen, req, "unexpected offer", 32'(seen), 32'h0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(!ex_valid, "R1", "valid after reset", 32'(ex_valid), 32'h0);
    chk(frame_idx == '1, "R1", "frame index after reset", 32'(frame_idx), 32'h7FF);
    chk(uframe == 3'd7, "R1", "microframe after reset", 32'(uframe), 32'h7);

    wpl(0, 0, 1, 0, 16'h0A00); wpl(0, 2, 1, 1, 16'h0A02); wpl(0, 3, 1, 2, 16'h0A03);
    wpl(1, 0, 1, 0, 16'h0B00); wpl(1, 1, 1, 1, 16'h0B01);
    waq(0, 1, 16'hC000); waq(2, 1, 16'hC002); waq(3, 1, 16'hC003);
    quiet(10, "R1");

    // table walk: R3 periodic order, R5 round-robin carry-over
    sof_pulse();
    for (int i = 0; i < 16; i++) begin
      take(VEC[i][15:0], VEC[i][16], VEC[i][16] ? "R5" : "R3");
      if (i < 15) begin
        if (VEC[i+1][17]) sof_pulse();
        done_pulse();
      end
    end
    chk(frame_idx == 11'd1, "R2", "frame index after 9 pulses", 32'(frame_idx), 32'h1);
    chk(uframe == 3'd0, "R2", "microframe after 9 pulses", 32'(uframe), 32'h0);

    // R6: remove slot 0, insert slot 1 while C003 is in flight
    waq(0, 0, 16'h0000); waq(1, 1, 16'hC001);
    done_pulse();
    take(16'hC001, 1'b1, "R6");
    done_pulse();
    take(16'hC002, 1'b1, "R6");

    // R7: threshold above any budget blocks async
    async_thr = BUD_W'(UF_CYCLES + 1);
    sof_pulse();
    done_pulse();
    quiet(20, "R7");
    async_thr = BUD_W'(UF_CYCLES - 20);
    sof_pulse();
    take(16'hC003, 1'b1, "R7");
    tick(30);
    done_pulse();
    quiet(20, "R7");

    // R4: interval filter in frame 2, periodic runs despite low budget
    async_thr = BUD_W'(UF_CYCLES + 1);
    wpl(2, 0, 1, 1, 16'hD000); wpl(2, 1, 1, 2, 16'hD001); wpl(2, 3, 1, 0, 16'hD003);
    wpl(3, 0, 1, 0, 16'hE000); wpl(3, 1, 1, 0, 16'hE001);
    repeat (5) begin sof_pulse(); tick(3); end
    quiet(5, "R3");
    sof_pulse();
    take(16'hD000, 1'b0, "R4");
    done_pulse();
    take(16'hD003, 1'b0, "R4");
    chk(frame_idx == 11'd2, "R2", "frame index in frame 2", 32'(frame_idx), 32'h2);
    done_pulse();
    quiet(20, "R7");

    // R9: pulse during a periodic dispatch abandons the row
    repeat (7) begin sof_pulse(); tick(3); end
    sof_pulse();
    take(16'hE000, 1'b0, "R9");
    async_thr = '0;
    sof_pulse();
    done_pulse();
    take(16'hC001, 1'b1, "R9");
    chk(uframe == 3'd1, "R9", "microframe after deferred pulse", 32'(uframe), 32'h1);
    done_pulse();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule